// File: doc/BRIEF.md
# Thermal Shutdown Supervisor with Hysteresis

This block decides when a battery charger must stop because its die has become too hot, and when it may start again. It receives a digitized die-temperature code together with a valid strobe, a programmable trip threshold and a programmable hysteresis amount. It also receives a flag that says a charge cycle is in progress, and the upstream enable requests for charging and for the three power outputs: the input-to-system path, the system rail and the load-switch/LDO rail.

The decision is a two-state machine. In `ST_NORMAL` every enable request passes through unchanged. The transition `GO_HOT` is taken when a valid sample arrives during charging with a code at or above the threshold. It moves the machine to `ST_SHUTDOWN`. In that state the charge enable and all three rail enables are forced low, and the safety-timer clear output is held high. The transition `COOL_OFF` is taken on a valid sample whose code lies strictly below the exit level. The exit level is the threshold minus the hysteresis, and it saturates at zero. `COOL_OFF` returns the machine to `ST_NORMAL`. When no transition applies, the machine holds its state (`STAY`).

The shutdown status flag and all gated outputs are decoded from the same state register, so they change on the same clock edge.

Top module: `thermal_guard`

## Requirements
- R1: After reset, `hot` is 0, `tmr_clr` is 0, and each enable output equals its request.
- R2: In `ST_NORMAL`, a cycle with `temp_vld`=1, `charging`=1 and `temp_code` >= `thresh` (unsigned 10-bit compare) sets `hot` to 1 on the next clock edge. A code of `thresh`-1 does not set it.
- R3: While `hot` is 1, `chg_en`, `pmid_en`, `sys_en` and `ldo_en` are all 0, whatever the requests are.
- R4: `tmr_clr` is 1 in every cycle that `hot` is 1, and 0 otherwise.
- R5: In `ST_SHUTDOWN`, a cycle with `temp_vld`=1 and `temp_code` < `thresh` - `hyst` clears `hot` on the next edge, whatever the value of `charging`. A code equal to the exit level keeps `hot` at 1.
- R6: While `charging` is 0, no code, however high, moves the block from `ST_NORMAL` to `ST_SHUTDOWN`.
- R7: While `temp_vld` is 0, `temp_code`, `thresh` and `hyst` are ignored and `hot` holds its value.
- R8: If `hyst` > `thresh`, the exit level saturates at 0, so no code clears `hot`. This includes a code of 0.
- R9: While `hot` is 0, each of `chg_en`, `pmid_en`, `sys_en` and `ldo_en` equals its own request input in the same cycle.
- R10: `hot`, `tmr_clr` and the gated enables change on the same clock edge. No cycle shows a new flag with old enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| temp_code | input | 10 | Unsigned die-temperature code |
| temp_vld | input | 1 | Strobe marking a valid temperature sample |
| thresh | input | 10 | Shutdown trip threshold |
| hyst | input | 10 | Hysteresis subtracted from the threshold to form the exit level |
| charging | input | 1 | A charge cycle is in progress |
| chg_req | input | 1 | Upstream charge enable request |
| pmid_req | input | 1 | Upstream input-to-system path enable request |
| sys_req | input | 1 | Upstream system rail enable request |
| ldo_req | input | 1 | Upstream load-switch/LDO enable request |
| chg_en | output | 1 | Gated charge enable |
| pmid_en | output | 1 | Gated input-to-system path enable |
| sys_en | output | 1 | Gated system rail enable |
| ldo_en | output | 1 | Gated load-switch/LDO enable |
| tmr_clr | output | 1 | Safety-timer clear, held for the whole shutdown |
| hot | output | 1 | Shutdown status flag |

## Verification
The bench exercises the trip point exactly at the threshold and one code below it. A design that used a strict compare would miss the trip at the threshold, and one that was off by one would trip one code early. It also places the temperature exactly on the exit level and one code under it. A design without the strict "below" test would leave shutdown too early, and one that ignored the hysteresis would leave at the threshold. A hysteresis larger than the threshold with a code of 0 catches a design whose exit level wraps around instead of saturating at zero, because that design would leave shutdown. Further cases cover a hot code while `charging` is low or while `temp_vld` is low, and request patterns applied in both states. Together these expose entry outside charging, action on invalid samples, and a rail that is left ungated.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
    typedef enum logic [0:0] {
        ST_NORMAL   = 1'b0,
        ST_SHUTDOWN = 1'b1
    } therm_state_t;

    localparam int unsigned N_GATED = 4;
    localparam int unsigned G_CHG  = 0;
    localparam int unsigned G_PMID = 1;
    localparam int unsigned G_SYS  = 2;
    localparam int unsigned G_LDO  = 3;
endpackage

// File: rtl/thermal_cmp.sv
module thermal_cmp #(
    parameter int unsigned TW = 10
) (
    input  logic [TW-1:0] temp_code,
    input  logic [TW-1:0] thresh,
    input  logic [TW-1:0] hyst,
    output logic          at_trip,
    output logic          below_exit
);
    logic [TW-1:0] exit_lvl;

    always_comb begin
        if (hyst > thresh) begin
            exit_lvl = '0;
        end else begin
            exit_lvl = thresh - hyst;
        end
        at_trip    = (temp_code >= thresh);
        below_exit = (temp_code < exit_lvl);
    end
endmodule

// File: rtl/thermal_fsm.sv
module thermal_fsm
    import thermal_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sample,
    input  logic         charging,
    input  logic         at_trip,
    input  logic         below_exit,
    output therm_state_t state
);
    therm_state_t state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_NORMAL: begin
                if (sample && charging && at_trip) begin
                    state_nx = ST_SHUTDOWN;
                end
            end
            ST_SHUTDOWN: begin
                if (sample && below_exit) begin
                    state_nx = ST_NORMAL;
                end
            end
            default: state_nx = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_NORMAL;
        end else begin
            state <= state_nx;
        end
    end
endmodule

// File: rtl/thermal_gate.sv
module thermal_gate #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] req,
    input  logic         block,
    output logic [N-1:0] en
);
    for (genvar i = 0; i < N; i++) begin : g_lane
        assign en[i] = req[i] & ~block;
    end
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
    import thermal_pkg::*;
#(
    parameter int unsigned TW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] temp_code,
    input  logic          temp_vld,
    input  logic [TW-1:0] thresh,
    input  logic [TW-1:0] hyst,
    input  logic          charging,
    input  logic          chg_req,
    input  logic          pmid_req,
    input  logic          sys_req,
    input  logic          ldo_req,
    output logic          chg_en,
    output logic          pmid_en,
    output logic          sys_en,
    output logic          ldo_en,
    output logic          tmr_clr,
    output logic          hot
);
    logic               at_trip;
    logic               below_exit;
    therm_state_t       state;
    logic               in_shdn;
    logic [N_GATED-1:0] req_vec;
    logic [N_GATED-1:0] en_vec;

    thermal_cmp #(.TW(TW)) u_cmp (
        .temp_code  (temp_code),
        .thresh     (thresh),
        .hyst       (hyst),
        .at_trip    (at_trip),
        .below_exit (below_exit)
    );

    thermal_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample     (temp_vld),
        .charging   (charging),
        .at_trip    (at_trip),
        .below_exit (below_exit),
        .state      (state)
    );

    assign in_shdn = (state == ST_SHUTDOWN);

    always_comb begin
        req_vec         = '0;
        req_vec[G_CHG]  = chg_req;
        req_vec[G_PMID] = pmid_req;
        req_vec[G_SYS]  = sys_req;
        req_vec[G_LDO]  = ldo_req;
    end

    thermal_gate #(.N(N_GATED)) u_gate (
        .req   (req_vec),
        .block (in_shdn),
        .en    (en_vec)
    );

    // Output decode: every output comes from the one state register.
    always_comb begin
        chg_en  = en_vec[G_CHG];
        pmid_en = en_vec[G_PMID];
        sys_en  = en_vec[G_SYS];
        ldo_en  = en_vec[G_LDO];
        tmr_clr = in_shdn;
        hot     = in_shdn;
    end
endmodule

// File: rtl/thermal_guard_chk.sv
module thermal_guard_chk #(
    parameter int unsigned TW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic [TW-1:0] temp_code,
    input logic          temp_vld,
    input logic [TW-1:0] thresh,
    input logic [TW-1:0] hyst,
    input logic          charging,
    input logic          chg_req,
    input logic          pmid_req,
    input logic          sys_req,
    input logic          ldo_req,
    input logic          chg_en,
    input logic          pmid_en,
    input logic          sys_en,
    input logic          ldo_en,
    input logic          tmr_clr,
    input logic          hot
);
    logic cool_hit;
    assign cool_hit = ({1'b0, temp_code} + {1'b0, hyst}) < {1'b0, thresh};

    AST_TRIP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!hot && temp_vld && charging && temp_code >= thresh) |=> hot); // R2

    AST_RAILS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        hot |-> (!chg_en && !pmid_en && !sys_en && !ldo_en)); // R3

    AST_TIMER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_clr == hot); // R4

    AST_COOL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (hot && temp_vld && cool_hit) |=> !hot); // R5

    AST_IDLE_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!hot && !charging) |=> !hot); // R6

    AST_NO_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !temp_vld |=> $stable(hot)); // R7

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !hot |-> (chg_en == chg_req && pmid_en == pmid_req &&
                  sys_en == sys_req && ldo_en == ldo_req)); // R9
endmodule

bind thermal_guard thermal_guard_chk #(.TW(TW)) u_chk (.*);

// File: tb/thermal_guard_test.sv
module thermal_guard_test;
    localparam int TW = 10;
    localparam int NV = 14;
    // row layout: {vld, charging, temp, thresh, hyst, expected hot}
    localparam logic [32:0] VEC [NV] = '{
        {1'b1, 1'b1, 10'd500, 10'd600, 10'd50,  1'b0},  // 0  R2 well below
        {1'b1, 1'b1, 10'd599, 10'd600, 10'd50,  1'b0},  // 1  R2 one below
        {1'b1, 1'b1, 10'd600, 10'd600, 10'd50,  1'b1},  // 2  R2 at trip
        {1'b1, 1'b1, 10'd560, 10'd600, 10'd50,  1'b1},  // 3  R5 inside band
        {1'b1, 1'b1, 10'd550, 10'd600, 10'd50,  1'b1},  // 4  R5 on exit level
        {1'b1, 1'b1, 10'd549, 10'd600, 10'd50,  1'b0},  // 5  R5 exit
        {1'b1, 1'b0, 10'd900, 10'd600, 10'd50,  1'b0},  // 6  R6 not charging
        {1'b0, 1'b1, 10'd900, 10'd600, 10'd50,  1'b0},  // 7  R7 no strobe
        {1'b1, 1'b1, 10'd900, 10'd600, 10'd50,  1'b1},  // 8  R2 trip
        {1'b0, 1'b1, 10'd5,   10'd600, 10'd50,  1'b1},  // 9  R7 no strobe
        {1'b1, 1'b0, 10'd5,   10'd600, 10'd50,  1'b0},  // 10 R5 exit off-charge
        {1'b1, 1'b1, 10'd100, 10'd100, 10'd200, 1'b1},  // 11 R2 trip
        {1'b1, 1'b1, 10'd0,   10'd100, 10'd200, 1'b1},  // 12 R8 saturated
        {1'b1, 1'b1, 10'd0,   10'd100, 10'd0,   1'b0}   // 13 R5 zero hyst
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] temp_code = '0;
    logic          temp_vld = 1'b0;
    logic [TW-1:0] thresh = '0;
    logic [TW-1:0] hyst = '0;
    logic          charging = 1'b0;
    logic          chg_req = 1'b1, pmid_req = 1'b1, sys_req = 1'b1, ldo_req = 1'b1;
    logic          chg_en, pmid_en, sys_en, ldo_en, tmr_clr, hot;
    int            n_chk = 0;
    int            n_err = 0;

    always #10 clk = ~clk;

    thermal_guard #(.TW(TW)) uut (
        .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .temp_vld(temp_vld),
        .thresh(thresh), .hyst(hyst), .charging(charging),
        .chg_req(chg_req), .pmid_req(pmid_req), .sys_req(sys_req), .ldo_req(ldo_req),
        .chg_en(chg_en), .pmid_en(pmid_en), .sys_en(sys_en), .ldo_en(ldo_en),
        .tmr_clr(tmr_clr), .hot(hot)
    );

    function automatic string row_tag(input int i);
        case (i)
            3, 4, 5, 10, 13: return "R5";
            6:               return "R6";
            7, 9:            return "R7";
            12:              return "R8";
            default:         return "R2";
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compare every output against the model for a given shutdown state.
    task automatic check_outs(input string tag, input logic exp_hot);
        logic [3:0] req;
        req = {chg_req, pmid_req, sys_req, ldo_req};
        check({tag, " hot"}, int'(hot), int'(exp_hot));
        check({tag, " R4 tmr_clr"}, int'(tmr_clr), int'(exp_hot));
        check({tag, exp_hot ? " R3 enables" : " R9 enables"},
              int'({chg_en, pmid_en, sys_en, ldo_en}),
              exp_hot ? 0 : int'(req));
    endtask

    task automatic step(input logic v, input logic c, input logic [TW-1:0] t,
                        input logic [TW-1:0] th, input logic [TW-1:0] hy);
        @(negedge clk);
        temp_vld = v; charging = c; temp_code = t; thresh = th; hyst = hy;
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        temp_vld = 1'b0; charging = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #4000000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        #2;
        check_outs("R1 reset", 1'b0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][32], VEC[i][31], VEC[i][30:21], VEC[i][20:11], VEC[i][10:1]);
            check_outs($sformatf("%s row %0d", row_tag(i), i), VEC[i][0]);
        end

        // R9: request patterns passed straight through in normal state
        do_reset();
        for (int p = 0; p < 16; p++) begin
            @(negedge clk);
            {chg_req, pmid_req, sys_req, ldo_req} = 4'(p);
            #2;
            check_outs($sformatf("R9 pattern %0d", p), 1'b0);
        end

        // R3: the same patterns are all blocked while in shutdown
        step(1'b1, 1'b1, 10'd1023, 10'd1023, 10'd0);
        for (int p = 0; p < 16; p++) begin
            @(negedge clk);
            {chg_req, pmid_req, sys_req, ldo_req} = 4'(p);
            #2;
            check_outs($sformatf("R3 pattern %0d", p), 1'b1);
        end

        // R10: flag and enables flip on the same edge, seen just after it
        chg_req = 1'b1; pmid_req = 1'b1; sys_req = 1'b1; ldo_req = 1'b1;
        step(1'b1, 1'b1, 10'd0, 10'd1023, 10'd0);
        check("R10 exit edge", int'({hot, tmr_clr, chg_en, pmid_en, sys_en, ldo_en}), 6'b001111);
        step(1'b1, 1'b1, 10'd0, 10'd0, 10'd0);
        check("R10 entry edge", int'({hot, tmr_clr, chg_en, pmid_en, sys_en, ldo_en}), 6'b110000);

        // R8: maximum hysteresis against a zero code holds shutdown
        step(1'b1, 1'b0, 10'd0, 10'd0, 10'd1023);
        check_outs("R8 max hyst", 1'b1);

        // R1: reset leaves shutdown immediately
        do_reset();
        #2;
        check_outs("R1 reset from shutdown", 1'b0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule